// File: doc/BRIEF.md
# Receive Queue with Per-Character Line Errors

This block is the character queue that sits between a serial receiver and the host. Each received character is stored with three error marks: parity, framing and break. The queue is show-ahead. The oldest stored character and its three marks are always present at the outputs. A host read strobe drops that character and presents the next one.

Two kinds of line status come out of the stored marks:

- The per-character marks of the head entry, which change on every read.
- A summary flag that stays high while any stored entry, head or not, carries at least one mark.

The summary is kept by a running tally of marked entries. It does not scan the storage.

When a character arrives and there is no room for it, the character is lost and a sticky overrun flag is raised. A read of the line status clears that flag. A flush strobe returns the whole queue to its empty state.

Top module: `rxq_errfifo`

## Requirements
- R1: After reset the queue reports empty, not full, level 0, no head marks, head data 0, summary flag low and overrun low.
- R2: A write while the queue is not full stores the character behind all earlier ones and raises level by one. Reads return characters in arrival order.
- R3: A read of a non-empty queue removes the head. In the following cycle, head data and the head marks show the next stored character. A read of an empty queue changes nothing.
- R4: While the queue is empty, head data and all three head marks read 0.
- R5: The summary flag is high exactly while at least one stored entry has a nonzero mark. It falls in the cycle after the last such entry is read out. Marks are written as {break, framing, parity} = {wr_brk, wr_ferr, wr_perr}.
- R6: A write to a full queue without a read in the same cycle is discarded. The stored contents and the level are unchanged, and overrun is set.
- R7: A read and a write in the same cycle on a full queue both take effect: level stays at DEPTH and overrun is not set. On an empty queue, the write is stored, the read is ignored, and level becomes 1.
- R8: Overrun stays set until a cycle with lsr_rd high. If a discarded write and lsr_rd fall in the same cycle, overrun ends that cycle set.
- R9: A flush strobe empties the queue, zeroes the marked-entry tally and clears overrun. It takes priority over a read or write in the same cycle, and those are ignored.
- R10: level equals the number of stored characters. empty is high exactly when level is 0, and full exactly when level is DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous queue reset strobe |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | DATA_W | Received character |
| wr_perr | input | 1 | Parity mark of the incoming character |
| wr_ferr | input | 1 | Framing mark of the incoming character |
| wr_brk | input | 1 | Break mark of the incoming character |
| rd_en | input | 1 | Host read of the head character |
| lsr_rd | input | 1 | Host read of line status; clears overrun |
| head_data | output | DATA_W | Oldest stored character, 0 when empty |
| head_perr | output | 1 | Parity mark of the head entry |
| head_ferr | output | 1 | Framing mark of the head entry |
| head_brk | output | 1 | Break mark of the head entry |
| err_any | output | 1 | Some stored entry carries a mark |
| empty | output | 1 | No character stored |
| full | output | 1 | DEPTH characters stored |
| level | output | clog2(DEPTH+1) | Number of stored characters |
| overrun | output | 1 | Sticky: a character was lost on a full queue |

## Verification
A read pointer that steps wrongly shows up one cycle after the offending read. The head data and marks then disagree with the arrival order.

A drift in the marked-entry tally stays hidden while marked entries remain stored. It surfaces in one of two ways:

- The summary flag stays high after the last marked character has drained.
- The summary flag is low while a marked character sits at the head.

For that reason, every sweep drains the queue fully and compares the summary flag after each single read. A wrong overrun or level update shows in the very next cycle, because both are compared after every edge.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

   localparam int ERR_W = 3;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rxq_err_t;

endpackage

// File: rtl/rxq_ptr.sv
`timescale 1ns/1ps
module rxq_ptr #(
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic                       pop,
   output logic [$clog2(DEPTH)-1:0]   wr_ptr,
   output logic [$clog2(DEPTH)-1:0]   rd_ptr,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       empty,
   output logic                       full
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP = CW'(DEPTH);

   logic [PW-1:0] wr_nxt;
   logic [PW-1:0] rd_nxt;

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else if (flush) begin
         level <= '0;
      end else begin
         unique case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign empty = (level == '0);
   assign full  = (level == CAP);

endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 11
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rxq_errtrack.sv
`timescale 1ns/1ps
module rxq_errtrack #(
   parameter int DEPTH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic push,
   input  logic push_marked,
   input  logic pop,
   input  logic pop_marked,
   input  logic drop,
   input  logic lsr_rd,
   output logic err_any,
   output logic overrun
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] tally;
   logic          inc;
   logic          dec;

   assign inc = push & push_marked;
   assign dec = pop & pop_marked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally <= '0;
      end else if (flush) begin
         tally <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   tally <= tally + 1'b1;
            2'b01:   tally <= tally - 1'b1;
            default: tally <= tally;
         endcase
      end
   end

   assign err_any = (tally != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      overrun <= 1'b0;
      else if (flush)  overrun <= 1'b0;
      else if (drop)   overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
   end

endmodule

// File: rtl/rxq_errfifo.sv
`timescale 1ns/1ps
module rxq_errfifo
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       wr_perr,
   input  logic                       wr_ferr,
   input  logic                       wr_brk,
   input  logic                       rd_en,
   input  logic                       lsr_rd,
   output logic [DATA_W-1:0]          head_data,
   output logic                       head_perr,
   output logic                       head_ferr,
   output logic                       head_brk,
   output logic                       err_any,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       overrun
);

   localparam int PW    = $clog2(DEPTH);
   localparam int ENT_W = DATA_W + ERR_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_errfifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rxq_errfifo: DATA_W must be at least 1");
      end
   endgenerate

   rxq_err_t          in_err;
   rxq_err_t          hd_err;
   logic [DATA_W-1:0] hd_data;
   logic [ENT_W-1:0]  wr_ent;
   logic [ENT_W-1:0]  rd_ent;
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr;
   logic              rd_ok;
   logic              wr_ok;
   logic              wr_drop;
   logic              q_empty;
   logic              q_full;

   assign in_err = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr};

   // Read only from a stored entry; a read frees a slot for a same-cycle write.
   assign rd_ok   = rd_en & ~q_empty & ~flush;
   assign wr_ok   = wr_en & ~flush & (~q_full | rd_ok);
   assign wr_drop = wr_en & ~flush & ~wr_ok;

   assign wr_ent = {in_err, wr_data};

   rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .push   (wr_ok),
      .pop    (rd_ok),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .level  (level),
      .empty  (q_empty),
      .full   (q_full)
   );

   rxq_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_store (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (wr_ptr),
      .wdata (wr_ent),
      .raddr (rd_ptr),
      .rdata (rd_ent)
   );

   assign hd_err  = rxq_err_t'(rd_ent[ENT_W-1:DATA_W]);
   assign hd_data = rd_ent[DATA_W-1:0];

   rxq_errtrack #(.DEPTH(DEPTH)) u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .push        (wr_ok),
      .push_marked (|in_err),
      .pop         (rd_ok),
      .pop_marked  (|hd_err),
      .drop        (wr_drop),
      .lsr_rd      (lsr_rd),
      .err_any     (err_any),
      .overrun     (overrun)
   );

   always_comb begin
      if (q_empty) begin
         head_data = '0;
         head_perr = 1'b0;
         head_ferr = 1'b0;
         head_brk  = 1'b0;
      end else begin
         head_data = hd_data;
         head_perr = hd_err.perr;
         head_ferr = hd_err.ferr;
         head_brk  = hd_err.brk;
      end
   end

   assign empty = q_empty;
   assign full  = q_full;

endmodule

// File: rtl/rxq_errfifo_chk.sv
`timescale 1ns/1ps
module rxq_errfifo_chk #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       flush,
   input logic                       wr_en,
   input logic                       rd_en,
   input logic                       lsr_rd,
   input logic [DATA_W-1:0]          head_data,
   input logic                       head_perr,
   input logic                       head_ferr,
   input logic                       head_brk,
   input logic                       err_any,
   input logic                       empty,
   input logic                       full,
   input logic [$clog2(DEPTH+1)-1:0] level,
   input logic                       overrun
);

   localparam int CW = $clog2(DEPTH + 1);

   AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full && !rd_en && !flush) |=> (level == CW'($past(level) + 1'b1))); // R2

   AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !empty && !wr_en && !flush) |=> (level == CW'($past(level) - 1'b1))); // R3

   AST_HEAD_MARK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (head_perr || head_ferr || head_brk) |-> err_any); // R5

   AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (!err_any && head_data == '0)); // R4

   AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en && !flush) |=> (overrun && full)); // R6

   AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && full && !flush && !overrun) |=> (full && !overrun)); // R7

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !lsr_rd && !flush) |=> overrun); // R8

   AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !err_any && !overrun)); // R9

   AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= CW'(DEPTH))); // R10

endmodule

bind rxq_errfifo rxq_errfifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .lsr_rd    (lsr_rd),
   .head_data (head_data),
   .head_perr (head_perr),
   .head_ferr (head_ferr),
   .head_brk  (head_brk),
   .err_any   (err_any),
   .empty     (empty),
   .full      (full),
   .level     (level),
   .overrun   (overrun)
);

// File: tb/tb_rxq_errfifo.sv
`timescale 1ns/1ps
module tb_rxq_errfifo;

   localparam int D  = 8;
   localparam int W  = 8;
   localparam int CW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          flush, wr_en, rd_en, lsr_rd;
   logic [W-1:0]  wr_data;
   logic          wr_perr, wr_ferr, wr_brk;
   logic [W-1:0]  head_data;
   logic          head_perr, head_ferr, head_brk;
   logic          err_any, empty, full, overrun;
   logic [CW-1:0] level;

   always #2 clk = ~clk;

   rxq_errfifo #(.DEPTH(D), .DATA_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
      .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en),
      .lsr_rd(lsr_rd), .head_data(head_data), .head_perr(head_perr),
      .head_ferr(head_ferr), .head_brk(head_brk), .err_any(err_any),
      .empty(empty), .full(full), .level(level), .overrun(overrun)
   );

   int    total = 0;
   int    bad   = 0;
   string scen  = "";
   logic [W+2:0] mq [$];   // {brk, ferr, perr, data}
   logic  movr = 1'b0;

   task automatic cmp(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, scen, what, act, exp);
      end
   endtask

   task automatic check_all();
      logic [W+2:0] h;
      int           marked;
      h = (mq.size() > 0) ? mq[0] : '0;
      marked = 0;
      foreach (mq[i]) if (mq[i][W+2:W] != 3'b000) marked++;
      cmp((mq.size() == 0) ? "R4" : "R2", "head_data", int'(head_data), int'(h[W-1:0]));
      cmp((mq.size() == 0) ? "R4" : "R3", "head_marks",
          int'({head_brk, head_ferr, head_perr}), int'(h[W+2:W]));
      cmp("R5", "err_any", int'(err_any), int'(marked != 0));
      cmp("R10", "level", int'(level), mq.size());
      cmp("R10", "empty", int'(empty), int'(mq.size() == 0));
      cmp("R10", "full", int'(full), int'(mq.size() == D));
      cmp("R8", "overrun", int'(overrun), int'(movr));
   endtask

   task automatic step(input logic wr, input logic [W-1:0] d, input logic [2:0] e,
                       input logic rd, input logic lsr, input logic fl);
      logic rdok, wrok;
      @(negedge clk);
      wr_en = wr; wr_data = d; {wr_brk, wr_ferr, wr_perr} = e;
      rd_en = rd; lsr_rd = lsr; flush = fl;
      @(posedge clk);
      if (fl) begin
         mq.delete();
         movr = 1'b0;
      end else begin
         rdok = rd && (mq.size() > 0);
         wrok = wr && ((mq.size() < D) || rdok);
         if (rdok) void'(mq.pop_front());
         if (wrok) mq.push_back({e, d});
         if (wr && !wrok) movr = 1'b1;
         else if (lsr)    movr = 1'b0;
      end
      #1;
      check_all();
   endtask

   task automatic idle();
      step(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      rst_n = 1'b0; flush = 0; wr_en = 0; rd_en = 0; lsr_rd = 0;
      wr_data = '0; wr_perr = 0; wr_ferr = 0; wr_brk = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      scen = "R1 reset state";
      check_all();

      // R3: read on empty queue has no effect
      scen = "R3 read empty";
      step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);

      // R5: each mark pattern alone raises and drops the summary
      for (int p = 0; p < 8; p++) begin
         scen = $sformatf("R5 single pattern %0d", p);
         step(1'b1, W'(8'hA0 + p), p[2:0], 1'b0, 1'b0, 1'b0);
         step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);
      end

      // R2 R6 R8: fill with every mark pattern, overflow, clear, drain
      for (int rot = 0; rot < 8; rot++) begin
         scen = $sformatf("R2 fill rot %0d", rot);
         for (int i = 0; i < D; i++)
            step(1'b1, W'(rot * 16 + i), 3'((i + rot) % 8), 1'b0, 1'b0, 1'b0);
         scen = "R6 write on full";
         step(1'b1, 8'hEE, 3'b111, 1'b0, 1'b0, 1'b0);
         idle();
         scen = "R8 status read clears";
         step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0);
         scen = "R7 full read and write";
         step(1'b1, 8'h5A, 3'(rot), 1'b1, 1'b0, 1'b0);
         scen = "R8 drop and status read together";
         step(1'b1, 8'h77, 3'b001, 1'b0, 1'b1, 1'b0);
         step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0);
         scen = $sformatf("R3 drain rot %0d", rot);
         for (int i = 0; i < D + 1; i++)
            step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);
      end

      // R7: read and write on empty queue
      scen = "R7 empty read and write";
      step(1'b1, 8'h3C, 3'b010, 1'b1, 1'b0, 1'b0);
      step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);

      // R9: flush with concurrent traffic
      scen = "R9 flush";
      for (int i = 0; i < D; i++) step(1'b1, W'(i), 3'b100, 1'b0, 1'b0, 1'b0);
      step(1'b1, 8'h11, 3'b001, 1'b0, 1'b0, 1'b0);
      step(1'b1, 8'h22, 3'b011, 1'b1, 1'b0, 1'b1);
      idle();

      // mixed sweep
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         scen = "R2 mixed sweep";
         step(lf[0], lf[11:4], lf[14:12] & {3{lf[1]}}, lf[2] ^ lf[3],
              lf[5] & lf[6] & lf[7], lf[15:9] == 7'h00);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule